// File: doc/BRIEF.md
# Modem Handshake Line Monitor

This block looks after the handshake side of a serial port. Four incoming modem lines (ring indicate, clear to send, carrier detect, data set ready) arrive asynchronously. Each passes through a multi-flop synchroniser. Software reads their settled levels from a line register.

Clear to send and carrier detect also feed edge detectors. When a line is selected by its mask bit, an edge on it latches a sticky event flag. A per-line "any edge" bit chooses what counts as an edge: with the bit set, both rising and falling edges are recorded; with it clear, only rising edges are. The event flags stay set until the line register is read, because that read clears them. The masked event flags are ORed into one interrupt request for the interrupt controller.

A control register drives the data terminal ready and request to send pins, and a loopback enable that goes to the serial datapath. Both handshake pins carry the inverse of the bit that was written. Register access uses single-cycle write and read strobes with a one-bit register select. Read data is registered, so it appears one cycle after the read strobe. This block has no streaming data interface, so every pin is a plain level or strobe.

Top module: `modem_line_monitor`

## Requirements
- R1: After reset the control bits, masks, any-edge bits and event flags are all 0, so dtr_n_o and rts_n_o are 1 and loop_en_o and irq_o are 0. A read of the control register returns 0x00.
- R2: A write with addr=0 stores wdata[0] (terminal ready), wdata[1] (send request) and wdata[2] (loopback). From the next cycle, dtr_n_o = ~wdata[0], rts_n_o = ~wdata[1] and loop_en_o = wdata[2]. A read with addr=0 returns {5'b0, loopback, send request, terminal ready}.
- R3: A read with addr=1 returns the synchronised line levels in bits [3:0], ordered ri (bit 0), cts (bit 1), dcd (bit 2), dsr (bit 3).
- R4: A write with addr=1 sets the masks and any-edge bits: wdata[4] is the cts mask, wdata[5] the dcd mask, wdata[6] the cts any-edge bit and wdata[7] the dcd any-edge bit. A masked line sets its event flag on a rising edge. It also sets the flag on a falling edge when its any-edge bit is 1. Read bits [5:4] are the cts and dcd event flags, and read bits [7:6] are the cts and dcd masks.
- R5: An edge on a line whose mask is 0 does not set that line's event flag.
- R6: irq_o is 1 exactly when some event flag is set and its mask is 1. Clearing a mask hides its flag from irq_o but keeps the flag, and setting the mask again raises irq_o again.
- R7: A read with addr=1 returns the flags as they were before the read and clears them in the same clock edge. rdata changes only on a read strobe.
- R8: An edge that is detected in the cycle of a clearing read leaves its event flag set.
- R9: Writing addr=1 with wdata[3:0] nonzero does not change the level bits.
- R10: A pin change becomes visible in the level bits after the synchroniser depth (2 clocks by default). The event flag sets one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select: 0 control, 1 lines |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ri_in | input | 1 | Ring indicate line (asynchronous) |
| cts_in | input | 1 | Clear to send line (asynchronous) |
| dcd_in | input | 1 | Carrier detect line (asynchronous) |
| dsr_in | input | 1 | Data set ready line (asynchronous) |
| dtr_n_o | output | 1 | Terminal ready pin, inverse of control bit 0 |
| rts_n_o | output | 1 | Send request pin, inverse of control bit 1 |
| loop_en_o | output | 1 | Loopback enable to the datapath |
| irq_o | output | 1 | Summary event request |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle. They also assume the strobes are low while reset is asserted. Their one-cycle look-back is therefore always taken over a defined, post-reset cycle. The bench drives every strobe and pin change on the falling clock edge and holds each strobe for exactly one cycle. A pin is never toggled again until the earlier edge has settled through the synchroniser, so each vector produces at most one edge per line. The same-cycle clear test is the only place where an edge is deliberately timed against the read strobe.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W    = 8;
  localparam int LINE_CNT = 4;
  localparam int EVT_CNT  = 2;
  localparam int CTRL_W   = 3;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_LINES = 1'b1
  } reg_sel_e;

  // control register bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_LOOP = 2;

  // line register field positions (read and write)
  localparam int LB_LVL  = 0;
  localparam int LB_STAT = 4;
  localparam int LB_MASK = 6;
  localparam int WB_MASK = 4;
  localparam int WB_ANY  = 6;

  // index of each line in the synchronised vector
  localparam int IX_RI  = 0;
  localparam int IX_CTS = 1;
  localparam int IX_DCD = 2;
  localparam int IX_DSR = 3;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_edge_flag.sv
module mdm_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic mask_i,
  input  logic any_edge_i,
  input  logic clear_i,
  output logic hit_o,
  output logic stat_o
);
  logic prev_q;
  logic rise, fall;

  assign rise  = level_i & ~prev_q;
  assign fall  = ~level_i & prev_q;
  assign hit_o = mask_i & (rise | (any_edge_i & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_o <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (hit_o)        stat_o <= 1'b1;  // set wins over clear
      else if (clear_i) stat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [EVT_CNT-1:0]  mask_q,
  output logic [EVT_CNT-1:0]  any_q
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-1:CTRL_W], wdata[WB_MASK-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      any_q  <= '0;
    end else if (wr_en) begin
      if (addr == SEL_CTRL) begin
        ctrl_q <= wdata[CTRL_W-1:0];
      end else begin
        mask_q <= wdata[WB_MASK +: EVT_CNT];
        any_q  <= wdata[WB_ANY  +: EVT_CNT];
      end
    end
  end
endmodule

// File: rtl/modem_line_monitor.sv
module modem_line_monitor
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             ri_in,
  input  logic             cts_in,
  input  logic             dcd_in,
  input  logic             dsr_in,
  output logic             dtr_n_o,
  output logic             rts_n_o,
  output logic             loop_en_o,
  output logic             irq_o
);
  localparam int PAD_W = REG_W - CTRL_W;

  logic [LINE_CNT-1:0] pins_raw, levels;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [EVT_CNT-1:0]  mask_q, any_q, stat_w, hit_w, evt_level;
  logic                clear_rd;

  assign pins_raw[IX_RI]  = ri_in;
  assign pins_raw[IX_CTS] = cts_in;
  assign pins_raw[IX_DCD] = dcd_in;
  assign pins_raw[IX_DSR] = dsr_in;

  mdm_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_raw), .sync_o(levels)
  );

  mdm_ctrl_reg u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .any_q(any_q)
  );

  assign evt_level[0] = levels[IX_CTS];
  assign evt_level[1] = levels[IX_DCD];
  assign clear_rd     = rd_en && (addr == SEL_LINES);

  for (genvar k = 0; k < EVT_CNT; k++) begin : g_evt
    mdm_edge_flag u_flag (
      .clk(clk), .rst_n(rst_n), .level_i(evt_level[k]), .mask_i(mask_q[k]),
      .any_edge_i(any_q[k]), .clear_i(clear_rd),
      .hit_o(hit_w[k]), .stat_o(stat_w[k])
    );
  end

  assign dtr_n_o   = ~ctrl_q[CB_DTR];
  assign rts_n_o   = ~ctrl_q[CB_RTS];
  assign loop_en_o = ctrl_q[CB_LOOP];
  assign irq_o     = |(stat_w & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == SEL_CTRL) rdata <= {{PAD_W{1'b0}}, ctrl_q};
      else                  rdata <= {mask_q, stat_w, levels};
    end
  end
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       dtr_n_o,
  input logic       rts_n_o,
  input logic       loop_en_o,
  input logic       irq_o,
  input logic [1:0] mask_q,
  input logic [1:0] stat_w,
  input logic [1:0] hit_w
);
  p_dtr_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !addr) |-> (dtr_n_o == ~$past(wdata[0])));
  p_rts_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !addr) |-> (rts_n_o == ~$past(wdata[1])));
  p_loop_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !addr) |-> (loop_en_o == $past(wdata[2])));
  p_cts_needs_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_w[0]) |-> $past(mask_q[0]));
  p_dcd_needs_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_w[1]) |-> $past(mask_q[1]));
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != 2'b00));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr && !hit_w[0]) |-> !stat_w[0]);
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_en) |-> $stable(rdata));
  p_edge_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr && hit_w[1]) |-> stat_w[1]);
endmodule

bind modem_line_monitor mdm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o),
  .loop_en_o(loop_en_o), .irq_o(irq_o), .mask_q(mask_q), .stat_w(stat_w),
  .hit_w(hit_w)
);

// File: tb/modem_line_monitor_tb.sv
module modem_line_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] pins = '0;  // {dsr, dcd, cts, ri}
  logic       dtr_n_o, rts_n_o, loop_en_o, irq_o;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  modem_line_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ri_in(pins[0]), .cts_in(pins[1]),
    .dcd_in(pins[2]), .dsr_in(pins[3]), .dtr_n_o(dtr_n_o),
    .rts_n_o(rts_n_o), .loop_en_o(loop_en_o), .irq_o(irq_o)
  );

  // {cfg[20:13], pins[12:9], exp_rdata[8:1], exp_irq[0]}
  localparam logic [20:0] VEC [10] = '{
    {8'hF0, 4'b0010, 8'hD2, 1'b1},  // R4 cts rise, any-edge
    {8'hF0, 4'b0000, 8'hD0, 1'b1},  // R4 cts fall, any-edge
    {8'h30, 4'b0100, 8'hE4, 1'b1},  // R4 dcd rise, rising only
    {8'h30, 4'b0000, 8'hC0, 1'b0},  // R4 dcd fall ignored
    {8'h00, 4'b0110, 8'h06, 1'b0},  // R5 unmasked rises
    {8'h10, 4'b0000, 8'h40, 1'b0},  // R5 falls, rising only / unmasked
    {8'h50, 4'b1011, 8'h5B, 1'b1},  // R3 levels, R4 cts rise
    {8'hA0, 4'b1101, 8'hAD, 1'b1},  // R4 dcd rise, R5 cts fall unmasked
    {8'hA0, 4'b1001, 8'hA9, 1'b1},  // R4 dcd fall, any-edge
    {8'h00, 4'b0000, 8'h00, 1'b0}   // R3 all low
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dtr_n", {7'b0, dtr_n_o}, 8'h01);
    check("R1 rts_n", {7'b0, rts_n_o}, 8'h01);
    check("R1 loop",  {7'b0, loop_en_o}, 8'h00);
    check("R1 irq",   {7'b0, irq_o}, 8'h00);
    rd(1'b0, got); check("R1 ctrl read", got, 8'h00);
    rd(1'b1, got); check("R1 line read", got, 8'h00);

    // table walk
    for (int i = 0; i < 10; i++) begin
      wr(1'b1, VEC[i][20:13]);
      @(negedge clk); pins = VEC[i][12:9];
      settle();
      check("R6 irq before read", {7'b0, irq_o}, {7'b0, VEC[i][0]});
      rd(1'b1, got);
      check("R4 line read", got, VEC[i][8:1]);
      check("R7 irq after read", {7'b0, irq_o}, 8'h00);
    end

    // R2 control pins
    wr(1'b0, 8'h01);
    check("R2 dtr_n low", {7'b0, dtr_n_o}, 8'h00);
    check("R2 rts_n high", {7'b0, rts_n_o}, 8'h01);
    wr(1'b0, 8'h06);
    check("R2 dtr_n high", {7'b0, dtr_n_o}, 8'h01);
    check("R2 rts_n low", {7'b0, rts_n_o}, 8'h00);
    check("R2 loop", {7'b0, loop_en_o}, 8'h01);
    rd(1'b0, got); check("R2 ctrl read", got, 8'h06);

    // R9 low nibble write ignored
    wr(1'b1, 8'h0F);
    rd(1'b1, got); check("R9 levels unchanged", got, 8'h00);

    // R10 latency: levels after 2 clocks, flag one clock later
    wr(1'b1, 8'hF0);
    @(negedge clk); pins = 4'b0001;
    @(negedge clk); @(negedge clk);
    rd(1'b1, got); check("R10 ri level", got, 8'hC1);
    @(negedge clk); pins = 4'b0000;
    settle();

    // R8 edge in same cycle as clearing read
    @(negedge clk); pins = 4'b0010;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R8 read shows old flag", rdata, 8'hC2);
    check("R8 irq still set", {7'b0, irq_o}, 8'h01);
    rd(1'b1, got); check("R8 flag kept", got, 8'hD2);

    // R6 mask hides and restores
    @(negedge clk); pins = 4'b0110;
    settle();
    check("R6 irq on dcd", {7'b0, irq_o}, 8'h01);
    wr(1'b1, 8'h00);
    check("R6 irq hidden", {7'b0, irq_o}, 8'h00);
    wr(1'b1, 8'hF0);
    check("R6 irq restored", {7'b0, irq_o}, 8'h01);
    rd(1'b1, got); check("R6 flag kept", got, 8'hE6);
    check("R7 cleared", {7'b0, irq_o}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule